// File: doc/BRIEF.md
# PCI Target Window Address Translator

This block sits behind the target side of a PCI host bridge. It compares each address that arrives from the external bus against six base-address windows. Each window is a naturally aligned power-of-two region, sized on its own. When a window matches, the block swaps the upper address bits for that window's local system-bus base. The lower bits inside the window pass through unchanged.

Each window has three registers: a size mask, a base as seen from the bus, and a local base. All three are loaded through a single-cycle write port. A size mask of zero turns the window off. Bit 3 of the size value marks the window as prefetchable.

For each access the block returns one registered result, one cycle later. The result carries a hit flag, the index of the matching window, the translated address and the prefetchable attribute.

Top module: `pci_tgt_xlat`

## Requirements
- R1: After reset, `rsp_valid_o`, `hit_o`, `win_o`, `xlat_addr_o` and `pref_o` are all zero. Every window starts disabled, so a request made straight after reset misses.
- R2: `rsp_valid_o` equals `req_valid_i` delayed by exactly one clock. All result fields appear in the same cycle as `rsp_valid_o`.
- R3: A request hits window i when window i is enabled and `(addr & M_i) == (bus_base_i & M_i)`. Here M_i is the size value with bits [3:0] forced to zero.
- R4: A window whose size bits [31:4] are all zero is disabled and never hits, whatever its bases hold.
- R5: On a hit, `xlat_addr_o = (loc_base_i & M_i) | (addr & ~M_i)`. The four lowest address bits therefore always pass through.
- R6: When several windows hit, the one with the lowest index is reported on `win_o` and used for translation.
- R7: On a hit, `pref_o` equals bit 3 of the winning window's size value. For example, a size value of 0xF000_0008 gives a 256 MB prefetchable window.
- R8: When the response is a miss, or there is no response, `hit_o`, `win_o`, `xlat_addr_o` and `pref_o` are all zero.
- R9: On a write, `cfg_sel_i` selects the register: 0 is the size value, 1 is the bus base and 2 is the local base. Code 3 is ignored, and so is a window index of `NUM_WIN` or above. A write is seen by a request presented in the following cycle.
- R10: `hit_o` is only ever asserted together with `rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_win_i | input | 3 | Window index to write |
| cfg_sel_i | input | 2 | Register select (0 size, 1 bus base, 2 local base) |
| cfg_data_i | input | 32 | Write data |
| req_valid_i | input | 1 | Address request valid |
| req_addr_i | input | 32 | Bus-side target address |
| rsp_valid_o | output | 1 | Registered response valid |
| hit_o | output | 1 | A window matched |
| win_o | output | 3 | Index of the matching window |
| xlat_addr_o | output | 32 | Translated local address |
| pref_o | output | 1 | Matched window is prefetchable |

## Verification
The bench targets overlapping windows, where a priority encoder biased the wrong way would report the higher index and translate with the wrong local base. It also disables a window that covers an address by writing a zero size. An enable test keyed off the wrong bits, or off the prefetch flag, would keep that window hitting. Writes with the unused select code and with window indices past the last window must leave every translation unchanged; an aliasing decoder would corrupt a live window. Random windows from 4 KB to 256 MB, some with the prefetch bit set, exercise the offset pass-through, which breaks if the mask is inverted or applied on the wrong side.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [1:0] {
    SEL_SIZE = 2'd0,
    SEL_BUS  = 2'd1,
    SEL_LOC  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int unsigned ATTR_BITS = 4;  // low bits of size value that are not mask
  localparam int unsigned PREF_BIT  = 3;
endpackage

// File: rtl/pci_tgt_win_regs.sv
module pci_tgt_win_regs
  import pci_tgt_pkg::*;
#(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WIN_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] mask_o [NUM_WIN],
  output logic              pref_o [NUM_WIN],
  output logic [ADDR_W-1:0] bus_o  [NUM_WIN],
  output logic [ADDR_W-1:0] loc_o  [NUM_WIN]
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic hit_wr;
    assign hit_wr = we_i && (win_i == WIN_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[g] <= '0;
        pref_o[g] <= 1'b0;
        bus_o[g]  <= '0;
        loc_o[g]  <= '0;
      end else if (hit_wr) begin
        unique case (cfg_sel_e'(sel_i))
          SEL_SIZE: begin
            mask_o[g] <= {data_i[ADDR_W-1:ATTR_BITS], {ATTR_BITS{1'b0}}};
            pref_o[g] <= data_i[PREF_BIT];
          end
          SEL_BUS:  bus_o[g] <= data_i;
          SEL_LOC:  loc_o[g] <= data_i;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pci_tgt_win_match.sv
module pci_tgt_win_match #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i [NUM_WIN],
  input  logic [ADDR_W-1:0] bus_i  [NUM_WIN],
  output logic [NUM_WIN-1:0] hit_o
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    logic en;
    assign en       = |mask_i[g];  // zero size disables the window
    assign hit_o[g] = en && ((addr_i & mask_i[g]) == (bus_i[g] & mask_i[g]));
  end
endmodule

// File: rtl/pci_tgt_prio.sv
module pci_tgt_prio #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned WIN_W   = 3
) (
  input  logic [NUM_WIN-1:0] hit_i,
  output logic               any_o,
  output logic [WIN_W-1:0]   idx_o
);
  always_comb begin
    any_o = |hit_i;
    idx_o = '0;
    // walk down so the lowest matching index is written last
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = WIN_W'(i);
    end
  end
endmodule

// File: rtl/pci_tgt_xlat.sv
module pci_tgt_xlat #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [WIN_W-1:0]  cfg_win_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [WIN_W-1:0]  win_o,
  output logic [ADDR_W-1:0] xlat_addr_o,
  output logic              pref_o
);
  logic [ADDR_W-1:0]  mask [NUM_WIN];
  logic               pref [NUM_WIN];
  logic [ADDR_W-1:0]  bus  [NUM_WIN];
  logic [ADDR_W-1:0]  loc  [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic               any_hit;
  logic [WIN_W-1:0]   sel_idx;
  logic [ADDR_W-1:0]  sel_mask, sel_loc, xlat_d;
  logic               sel_pref, take;

  pci_tgt_win_regs #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .win_i  (cfg_win_i),
    .sel_i  (cfg_sel_i),
    .data_i (cfg_data_i),
    .mask_o (mask),
    .pref_o (pref),
    .bus_o  (bus),
    .loc_o  (loc)
  );

  pci_tgt_win_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_match (
    .addr_i (req_addr_i),
    .mask_i (mask),
    .bus_i  (bus),
    .hit_o  (hit_vec)
  );

  pci_tgt_prio #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_prio (
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (sel_idx)
  );

  always_comb begin
    sel_mask = '0;
    sel_loc  = '0;
    sel_pref = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel_idx == WIN_W'(i)) begin
        sel_mask = mask[i];
        sel_loc  = loc[i];
        sel_pref = pref[i];
      end
    end
    xlat_d = (sel_loc & sel_mask) | (req_addr_i & ~sel_mask);
    take   = req_valid_i && any_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      win_o       <= '0;
      xlat_addr_o <= '0;
      pref_o      <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      hit_o       <= take;
      win_o       <= take ? sel_idx  : '0;
      xlat_addr_o <= take ? xlat_d   : '0;
      pref_o      <= take && sel_pref;
    end
  end
endmodule

// File: rtl/pci_tgt_xlat_chk.sv
module pci_tgt_xlat_chk #(
  parameter int unsigned NUM_WIN = 6,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WIN_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [3:0]        req_addr_lo_i,
  input logic              rsp_valid_o,
  input logic              hit_o,
  input logic [WIN_W-1:0]  win_o,
  input logic [ADDR_W-1:0] xlat_addr_o,
  input logic              pref_o
);
  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  p_hit_needs_rsp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> rsp_valid_o);

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (xlat_addr_o == '0 && win_o == '0 && !pref_o));

  p_win_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (win_o < WIN_W'(NUM_WIN)));

  p_offset_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (xlat_addr_o[3:0] == $past(req_addr_lo_i)));
endmodule

bind pci_tgt_xlat pci_tgt_xlat_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_addr_lo_i (req_addr_i[3:0]),
  .rsp_valid_o   (rsp_valid_o),
  .hit_o         (hit_o),
  .win_o         (win_o),
  .xlat_addr_o   (xlat_addr_o),
  .pref_o        (pref_o)
);

// File: tb/pci_tgt_xlat_bench.sv
module pci_tgt_xlat_bench;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, hit;
  logic [2:0]  win;
  logic [31:0] xa;
  logic        pref;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_size [NW];
  logic [31:0] m_bus  [NW];
  logic [31:0] m_loc  [NW];

  always #2 clk = ~clk;

  pci_tgt_xlat u_pci_tgt_xlat (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_win_i(cfg_win), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .win_o(win), .xlat_addr_o(xa), .pref_o(pref)
  );

  function automatic logic [37:0] expect_rsp(input logic [31:0] a);
    logic [31:0] m;
    for (int i = 0; i < NW; i++) begin
      m = {m_size[i][31:4], 4'h0};
      if (m != 0 && ((a & m) == (m_bus[i] & m)))
        return {1'b1, 3'(i), ((m_loc[i] & m) | (a & ~m)), m_size[i][3], 1'b1};
    end
    return {1'b0, 3'd0, 32'd0, 1'b0, 1'b1};
  endfunction

  task automatic check(input string req, input logic [37:0] exp);
    logic [37:0] act;
    act = {hit, win, xa, pref, rsp_valid};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act hit=%0b win=%0d xa=%08h pref=%0b vld=%0b exp hit=%0b win=%0d xa=%08h pref=%0b vld=%0b",
               req, act[37], act[36:34], act[33:2], act[1], act[0],
               exp[37], exp[36:34], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = w; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (w < 3'(NW)) begin
      case (s)
        2'd0: m_size[w] = d;
        2'd1: m_bus[w]  = d;
        2'd2: m_loc[w]  = d;
        default: ;
      endcase
    end
  endtask

  task automatic req(input string tag, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, expect_rsp(a));
  endtask

  task automatic rand_windows();
    for (int i = 0; i < NW; i++) begin
      int k;
      logic [31:0] m;
      k = 12 + int'($urandom % 17);
      m = ~((32'd1 << k) - 32'd1);
      if ($urandom % 5 == 0) wr(3'(i), 2'd0, 32'd0);
      else wr(3'(i), 2'd0, m | (($urandom % 2 == 0) ? 32'h8 : 32'h0));
      wr(3'(i), 2'd1, $urandom & m);
      wr(3'(i), 2'd2, $urandom & m);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin m_size[i] = 0; m_bus[i] = 0; m_loc[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {1'b0, 3'd0, 32'd0, 1'b0, 1'b0});
    rst_n = 1'b1;
    req("R1,R4 all windows off", 32'h0000_0000);

    // R7, R3, R5 256 MB prefetchable window
    wr(3'd0, 2'd0, 32'hF000_0008);
    wr(3'd0, 2'd1, 32'h4000_0000);
    wr(3'd0, 2'd2, 32'h8000_0000);
    req("R3,R5,R7 256MB pref", 32'h4123_4567);
    req("R3 outside window", 32'h5000_0000);

    // R9 unused select code and out-of-range windows
    wr(3'd0, 2'd3, 32'hFFFF_FFFF);
    wr(3'd6, 2'd0, 32'hFFFF_0000);
    wr(3'd7, 2'd1, 32'h5000_0000);
    wr(3'd6, 2'd1, 32'h5000_0000);
    req("R9 ignored writes keep win0", 32'h4123_4567);
    req("R9 ignored windows never hit", 32'h5000_0010);

    // R6 overlap: window 2 inside window 0
    wr(3'd2, 2'd0, 32'hFFFF_0000);
    wr(3'd2, 2'd1, 32'h4001_0000);
    wr(3'd2, 2'd2, 32'h1234_0000);
    req("R6 lowest index wins", 32'h4001_0020);
    // R4 zero size disables window 0
    wr(3'd0, 2'd0, 32'h0000_0008);
    req("R4 disabled win0, win2 takes", 32'h4001_0020);
    req("R4 disabled win0 misses", 32'h4123_4567);

    // R2, R8, R10 idle cycle
    @(negedge clk);
    check("R2,R8,R10 idle", {1'b0, 3'd0, 32'd0, 1'b0, 1'b0});

    // back-to-back requests for R2
    @(negedge clk); req_valid = 1'b1; req_addr = 32'h4001_FFFF;
    @(negedge clk); check("R2 back-to-back a", expect_rsp(32'h4001_FFFF)); req_addr = 32'h0000_1000;
    @(negedge clk); req_valid = 1'b0; check("R2 back-to-back b", expect_rsp(32'h0000_1000));

    // random windows and addresses
    for (int r = 0; r < 20; r++) begin
      rand_windows();
      for (int v = 0; v < 40; v++) begin
        logic [31:0] a;
        int j;
        j = int'($urandom % NW);
        if ($urandom % 3 != 0)
          a = (m_bus[j] & {m_size[j][31:4], 4'h0}) | ($urandom & ~{m_size[j][31:4], 4'h0});
        else
          a = $urandom;
        req("R3,R4,R5,R6,R7,R8 random", a);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule